// File: doc/BRIEF.md
# Microcontroller Interrupt Controller

This block collects interrupt events for a small 8-bit core. There are four sources: two timer event pulses (timer A and timer B) and two active-low external pins (pin 0 and pin 1). Each event latches a flag in a request register that software can read. The block combines the flags with a per-source enable register and a global enable bit, and raises a request to the core. The core takes the interrupt at an instruction boundary and jumps to a fixed vector address.

Taking an interrupt clears the global enable, so the service routine is never interrupted a second time. The core's return-from-interrupt pulse sets the global enable again. The hardware applies no priority. The service routine reads the flag register and chooses which source to serve first.

External pin edges also drive a wake request. The wake request depends only on the synchronized edge and the pin's enable bit, so a power-down controller can use it to restart the clock.

Top module: `irq_hub`

## Requirements
- R1: After reset, the enable register, the flag register and the global enable bit are all 0, and reads of every register return 0x00.
- R2: The enable register is at address 0xC9. Bit 6 enables timer B, bit 5 enables timer A, bit 1 enables pin 1 and bit 0 enables pin 0. Bits 7, 4, 3 and 2 ignore writes and read back as 0.
- R3: The flag register is at address 0xC8 and uses the same bit positions as the enable register. A source event sets its flag whatever the enable and global enable settings are. Unused bits read as 0.
- R4: Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. If a source event arrives in the same cycle as a clear of its flag, the flag stays set.
- R5: Each pin is passed through a two-flop synchronizer. A falling edge on the pin sets its flag at the third rising clock edge after the pin changes. A rising edge sets nothing.
- R6: `irq_req` equals the global enable ANDed with the OR, over all sources, of flag AND enable.
- R7: `irq_take` is high exactly when `irq_req` and `insn_boundary` are both high. `vec_addr` is always 8. After a cycle in which `irq_take` is high, the global enable is 0.
- R8: A `reti_exec` pulse sets the global enable to 1 at the next edge, unless an interrupt is taken in the same cycle.
- R9: The global enable is bit 7 of the control register at address 0xCA. Its other bits read as 0. When several updates land in the same cycle, taking an interrupt wins over `reti_exec`, and `reti_exec` wins over a bus write.
- R10: `wake_req` is high while a synchronized pin falling edge coincides with that pin's enable bit. It does not depend on the global enable or on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tmr_a_evt | input | 1 | Timer A event pulse |
| tmr_b_evt | input | 1 | Timer B event pulse |
| pin_n | input | 2 | Asynchronous external pins, active low |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| reti_exec | input | 1 | Core executes return-from-interrupt |
| irq_req | output | 1 | Pending enabled request with global enable set |
| irq_take | output | 1 | Vector handshake: interrupt accepted this cycle |
| vec_addr | output | 12 | Interrupt vector address |
| wake_req | output | 1 | Wake request from an enabled pin edge |

## Verification
The assertions check on every cycle that the global enable falls after a take and rises after a return. They also check that no request appears while the global enable is 0, that a take only happens at a boundary with a request pending, that flags drop only through writes to the flag register, and that a wake needs an enabled pin. Some behaviours show up only in the bench scenarios: the exact synchronizer latency, an event winning over a simultaneous clear, the ordering of simultaneous global-enable updates, and the read-back masking of unused bits. The bench checks these against its cycle model.

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int           AW        = 8,
  parameter int           PC_W      = 12,
  parameter logic [AW-1:0] FLAG_ADDR = 8'hC8,
  parameter logic [AW-1:0] EN_ADDR   = 8'hC9,
  parameter logic [AW-1:0] CTRL_ADDR = 8'hCA,
  parameter int           GIE_BIT   = 7,
  parameter int           VECTOR    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic            tmr_a_evt,
  input  logic            tmr_b_evt,
  input  logic [1:0]      pin_n,
  input  logic            insn_boundary,
  input  logic            reti_exec,
  output logic            irq_req,
  output logic            irq_take,
  output logic [PC_W-1:0] vec_addr,
  output logic            wake_req
);

  localparam int         NPIN     = 2;
  localparam logic [7:0] SRC_MASK = 8'b0110_0011;

  logic [7:0]      en_q, flag_q, evt, clr;
  logic            gie_q;
  logic [NPIN-1:0] sync1, sync2, prev, fall;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sync1[i] <= 1'b1;
        sync2[i] <= 1'b1;
        prev[i]  <= 1'b1;
      end else begin
        sync1[i] <= pin_n[i];
        sync2[i] <= sync1[i];
        prev[i]  <= sync2[i];
      end
    end
    assign fall[i] = prev[i] & ~sync2[i];
  end

  logic wr_en, wr_flag, wr_ctrl;
  assign wr_en   = bus_wr && (bus_addr == EN_ADDR);
  assign wr_flag = bus_wr && (bus_addr == FLAG_ADDR);
  assign wr_ctrl = bus_wr && (bus_addr == CTRL_ADDR);

  assign evt = {1'b0, tmr_b_evt, tmr_a_evt, 3'b000, fall};
  assign clr = wr_flag ? ~bus_wdata : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 8'h00;
      flag_q <= 8'h00;
    end else begin
      if (wr_en) en_q <= bus_wdata & SRC_MASK;
      flag_q <= (evt | (flag_q & ~clr)) & SRC_MASK;
    end
  end

  assign irq_req  = gie_q && |(flag_q & en_q);
  assign irq_take = irq_req && insn_boundary;
  assign vec_addr = PC_W'(VECTOR);

  always_ff @(posedge clk) begin
    if (!rst_n)         gie_q <= 1'b0;
    else if (irq_take)  gie_q <= 1'b0;
    else if (reti_exec) gie_q <= 1'b1;
    else if (wr_ctrl)   gie_q <= bus_wdata[GIE_BIT];
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == EN_ADDR)   bus_rdata = en_q;
    if (bus_addr == FLAG_ADDR) bus_rdata = flag_q;
    if (bus_addr == CTRL_ADDR) bus_rdata[GIE_BIT] = gie_q;
  end

  assign wake_req = |(fall & en_q[NPIN-1:0]);

endmodule

module irq_hub_chk #(
  parameter int            AW        = 8,
  parameter logic [AW-1:0] FLAG_ADDR = 8'hC8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          insn_boundary,
  input logic          reti_exec,
  input logic          irq_req,
  input logic          irq_take,
  input logic          wake_req,
  input logic          gie_q,
  input logic [7:0]    en_q,
  input logic [7:0]    flag_q
);

  a_r7_take_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !gie_q);

  a_r8_reti_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_exec && !irq_take) |=> gie_q);

  a_r6_no_req_without_gie: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !irq_req);

  a_r7_take_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (insn_boundary && irq_req));

  a_r4_flags_drop_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == FLAG_ADDR) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  a_r10_wake_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (en_q[1:0] != 2'b00));

endmodule

bind irq_hub irq_hub_chk #(.AW(AW), .FLAG_ADDR(FLAG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .insn_boundary(insn_boundary), .reti_exec(reti_exec),
  .irq_req(irq_req), .irq_take(irq_take), .wake_req(wake_req),
  .gie_q(gie_q), .en_q(en_q), .flag_q(flag_q)
);

// File: tb/tb_irq_hub.sv
module tb_irq_hub;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_FLAG = 8'hC8, A_EN = 8'hC9, A_CTRL = 8'hCA;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic tmr_a_evt = 0, tmr_b_evt = 0;
  logic [1:0] pin_n = 2'b11;
  logic insn_boundary = 0, reti_exec = 0;
  logic irq_req, irq_take, wake_req;
  logic [11:0] vec_addr;

  int n_cmp = 0, n_bad = 0;

  irq_hub dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_a_evt(tmr_a_evt),
    .tmr_b_evt(tmr_b_evt), .pin_n(pin_n), .insn_boundary(insn_boundary),
    .reti_exec(reti_exec), .irq_req(irq_req), .irq_take(irq_take),
    .vec_addr(vec_addr), .wake_req(wake_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  int m_en = 0, m_flag = 0;
  bit m_gie = 0;
  bit h0[$] = '{1, 1, 1};
  bit h1[$] = '{1, 1, 1};

  function automatic bit m_fall(int p);
    if (p == 0) return h0[2] && !h0[1];
    return h1[2] && !h1[1];
  endfunction

  function automatic int m_rdata();
    if (bus_addr == A_EN)   return m_en;
    if (bus_addr == A_FLAG) return m_flag;
    if (bus_addr == A_CTRL) return m_gie ? 8'h80 : 0;
    return 0;
  endfunction

  function automatic bit m_req();
    return m_gie && ((m_flag & m_en) != 0);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string t;
    if (!rst_n) return;
    t = (bus_addr == A_CTRL) ? "R9 rdata" : (bus_addr == A_FLAG) ? "R3 rdata" : "R2 rdata";
    check(t, bus_rdata, m_rdata());
    check("R6 irq_req", irq_req, m_req());
    check("R7 irq_take", irq_take, m_req() && insn_boundary);
    check("R7 vec_addr", vec_addr, 8);
    check("R10 wake_req", wake_req, (m_fall(0) && m_en[0]) || (m_fall(1) && m_en[1]));
  endtask

  task automatic model_update();
    int ev;
    bit take;
    if (!rst_n) begin
      m_en = 0; m_flag = 0; m_gie = 0;
      h0 = '{1, 1, 1}; h1 = '{1, 1, 1};
      return;
    end
    take = m_req() && insn_boundary;
    ev = (tmr_b_evt ? 8'h40 : 0) | (tmr_a_evt ? 8'h20 : 0) |
         (m_fall(1) ? 8'h02 : 0) | (m_fall(0) ? 8'h01 : 0);
    if (bus_wr && bus_addr == A_FLAG) m_flag = m_flag & bus_wdata;
    m_flag = (m_flag | ev) & 8'h63;
    if (bus_wr && bus_addr == A_EN) m_en = bus_wdata & 8'h63;
    if (take) m_gie = 0;
    else if (reti_exec) m_gie = 1;
    else if (bus_wr && bus_addr == A_CTRL) m_gie = bus_wdata[7];
    h0.push_front(pin_n[0]); void'(h0.pop_back());
    h1.push_front(pin_n[1]); void'(h1.pop_back());
  endtask

  task automatic tick();
    #(CLK_PERIOD/4);
    compare_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
    bus_wr = 0; tmr_a_evt = 0; tmr_b_evt = 0; insn_boundary = 0; reti_exec = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; tick();
  endtask

  task automatic rd_check(string tag, logic [7:0] a, int exp);
    bus_addr = a; #1; check(tag, bus_rdata, exp); tick();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rst_n = 1;
    // R1 reset values
    rd_check("R1 enable reset", A_EN, 0);
    rd_check("R1 flag reset", A_FLAG, 0);
    rd_check("R1 ctrl reset", A_CTRL, 0);
    // R2 unused bits masked
    wr(A_EN, 8'hFF);
    rd_check("R2 enable mask", A_EN, 8'h63);
    wr(A_EN, 8'h00);
    // R3 flags set with enable off
    tmr_a_evt = 1; tick();
    rd_check("R3 timer A flag", A_FLAG, 8'h20);
    tmr_b_evt = 1; tick();
    rd_check("R3 timer B flag", A_FLAG, 8'h60);
    // R4 clear by 0, 1 keeps, event wins
    wr(A_FLAG, 8'hFF);
    rd_check("R4 write one keeps", A_FLAG, 8'h60);
    wr(A_FLAG, 8'hDF);
    rd_check("R4 clear timer A", A_FLAG, 8'h40);
    tmr_b_evt = 1; bus_wr = 1; bus_addr = A_FLAG; bus_wdata = 8'h00; tick();
    rd_check("R4 event beats clear", A_FLAG, 8'h40);
    wr(A_FLAG, 8'h00);
    // R5 pin falling edge, three edges of latency; R10 wake
    wr(A_EN, 8'h01);
    pin_n = 2'b10; bus_addr = A_FLAG;
    tick(); tick();
    #1; check("R10 wake on edge", wake_req, 1);
    check("R5 not yet set", bus_rdata, 0);
    tick();
    rd_check("R5 pin0 flag set", A_FLAG, 8'h01);
    pin_n = 2'b11; repeat (4) tick();
    rd_check("R5 rising edge no flag", A_FLAG, 8'h01);
    pin_n = 2'b01; repeat (4) tick();
    rd_check("R5 pin1 flag, no enable", A_FLAG, 8'h03);
    pin_n = 2'b11; repeat (3) tick();
    // R6/R7/R8 take and return
    check("R6 no req without gie", irq_req, 0);
    wr(A_CTRL, 8'h80);
    #1; check("R6 req with gie", irq_req, 1);
    insn_boundary = 1; #1; check("R7 take", irq_take, 1); tick();
    rd_check("R7 gie cleared", A_CTRL, 0);
    reti_exec = 1; tick();
    rd_check("R8 reti sets gie", A_CTRL, 8'h80);
    // R9 ordering
    insn_boundary = 1; reti_exec = 1; tick();
    rd_check("R9 take beats reti", A_CTRL, 0);
    reti_exec = 1; bus_wr = 1; bus_addr = A_CTRL; bus_wdata = 8'h00; tick();
    rd_check("R9 reti beats write", A_CTRL, 8'h80);
    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      bus_wr = ($urandom % 4) == 0;
      bus_addr = 8'hC7 + 8'($urandom % 5);
      bus_wdata = 8'($urandom);
      tmr_a_evt = ($urandom % 6) == 0;
      tmr_b_evt = ($urandom % 6) == 0;
      if (($urandom % 5) == 0) pin_n = 2'($urandom);
      insn_boundary = ($urandom % 2) == 0;
      reti_exec = ($urandom % 8) == 0;
      tick();
    end
    finish_run();
  end
endmodule